// File: doc/BRIEF.md
# Serial Programming Command Target

This block is the device side of a four-byte serial programming link. An external programmer drives a serial clock and a data-in line while the chip is held in its programming state. The block rebuilds each instruction from the data-in line and returns one response byte per instruction on the data-out line. A page-load instruction fills an on-block page buffer. A page-write instruction then commits that buffer to a memory array outside the block through a simple write port. A read port fetches single locations for read-back.

The serial clock is treated as a slow signal. It is synchronised into the system clock domain and reduced to rising-edge and falling-edge events. Inbound bits are taken on rising edges and outbound bits change on falling edges. A parameterised busy window follows every commit. During that window a poll instruction reports the busy state, and every other memory instruction is dropped.

Top module: `spx_target`

## Requirements
- R1: Data-in is sampled on each rising serial clock edge, most significant bit first. Every instruction is exactly four bytes, numbered 1 to 4.
- R2: Data-out changes only after a falling serial clock edge, and is low after reset. The response to byte N is shifted out during byte N+1, most significant bit first.
- R3: During byte 3 of any instruction, data-out carries the value received as byte 2. For the enable instruction this is 0x53.
- R4: Until an enable instruction has completed, every other instruction is ignored. No memory write is issued, and reads and polls return 0x00 in byte 4.
- R5: The enable instruction is byte 1 = 0xAC with byte 2 = 0x53. It takes effect at the end of byte 4.
- R6: Opcode 0x40 stores byte 4 as the low half of buffer word byte3[5:0]. Opcode 0x48 stores the high half. A high-half load is ignored unless the low half of that word has been loaded since the last flash commit.
- R7: Opcode 0x4C writes all 64 buffer words, in ascending word order, to word addresses {page, word}. Here page = {byte2,byte3}[12:6]. Halves never loaded are written as 0xFF. The flash buffer returns to all ones after the commit.
- R8: Opcode 0xC1 loads EEPROM buffer byte byte3[5:0]. Opcode 0xC2 writes only the loaded bytes, in ascending order, to {page, byte}, with page = {byte2,byte3}[12:6]. All loaded flags are then cleared, and other locations keep their content.
- R9: Opcode 0xC0 writes byte 4 to EEPROM address {byte2,byte3}[12:0] in one write, with write data {0x00, byte4}. The location afterwards holds exactly byte 4, whatever it held before.
- R10: Opcodes 0x20 (flash low half), 0x28 (flash high half) and 0xA0 (EEPROM) return the addressed content in byte 4. The address is {byte2,byte3}[12:0].
- R11: After a write instruction the block is busy until the commit ends, plus BUSY_CYCLES clocks. Opcode 0xF0 returns the busy state in bit 0 of byte 4. Load, write and read instructions that arrive while busy are ignored, and such reads return 0x00.
- R12: While programming-active is low, the byte counter, the bit counter and the enable state are held cleared, and data-out is low.
- R13: The memory write strobe is raised only while the block is busy, one location per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_active | input | 1 | High while the chip is in programming mode |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| mem_we | output | 1 | Memory write strobe, one location per clock |
| mem_eep | output | 1 | Write target: 1 for EEPROM, 0 for flash |
| mem_waddr | output | ADDR_W | Write address, in words for flash and bytes for EEPROM |
| mem_wdata | output | 16 | Write data; EEPROM uses bits 7:0 and has 0 in bits 15:8 |
| mem_raddr | output | ADDR_W | Read address |
| mem_reep | output | 1 | Read target: 1 for EEPROM, 0 for flash |
| mem_rdata | input | 16 | Read data, valid one clock after mem_raddr changes |

## Verification
The same read and write instructions are sent three times: before enable, after enable, and inside a busy window. Comparing the three results shows that the enable gate and the busy gate act separately. For flash pages, the bench loads a word with both halves, a word whose high half arrives with no low half, and words never touched, then commits the page twice. This separates ordering enforcement, fill with ones, and buffer reset. For EEPROM pages, a sparse set of loaded bytes is committed over a preloaded page, then the same page is committed again. This shows that untouched bytes are kept and that the loaded flags are cleared. Finally, programming-active is dropped in the middle of an instruction, which shows that it realigns the byte counter and withdraws enable.

// File: rtl/spx_pkg.sv
package spx_pkg;

   localparam logic [7:0] OP_ENABLE     = 8'hAC;
   localparam logic [7:0] SYNC_BYTE     = 8'h53;
   localparam logic [7:0] OP_LD_FL_LO   = 8'h40;
   localparam logic [7:0] OP_LD_FL_HI   = 8'h48;
   localparam logic [7:0] OP_WR_FL_PG   = 8'h4C;
   localparam logic [7:0] OP_LD_EE      = 8'hC1;
   localparam logic [7:0] OP_WR_EE_PG   = 8'hC2;
   localparam logic [7:0] OP_WR_EE_BYTE = 8'hC0;
   localparam logic [7:0] OP_RD_FL_LO   = 8'h20;
   localparam logic [7:0] OP_RD_FL_HI   = 8'h28;
   localparam logic [7:0] OP_RD_EE      = 8'hA0;
   localparam logic [7:0] OP_POLL       = 8'hF0;

   typedef enum logic [1:0] {
      CK_FLASH_PAGE = 2'd0,
      CK_EE_PAGE    = 2'd1,
      CK_EE_BYTE    = 2'd2
   } commit_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_HOLD = 2'd2
   } seq_state_e;

endpackage

// File: rtl/spx_shifter.sv
module spx_shifter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       sck_i,
   input  logic       mosi_i,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic [1:0] byte_idx,
   output logic       miso_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spx_shifter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sck_sync;
   logic [SYNC_STAGES-1:0] mosi_sync;
   logic                   sck_prev;
   logic                   sck_s;
   logic                   mosi_s;
   logic                   rise;
   logic                   fall;
   logic [6:0]             rx_sh;
   logic [2:0]             bit_cnt;
   logic [1:0]             cur_idx;
   logic [7:0]             tx_sh;
   logic [7:0]             tx_nxt;

   assign sck_s  = sck_sync[SYNC_STAGES-1];
   assign mosi_s = mosi_sync[SYNC_STAGES-1];
   assign rise   = active & sck_s & ~sck_prev;
   assign fall   = active & ~sck_s & sck_prev;
   assign tx_nxt = tx_load ? tx_byte : tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sync  <= '0;
         mosi_sync <= '0;
         sck_prev  <= 1'b0;
      end else begin
         sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
         mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
         sck_prev  <= sck_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh     <= '0;
         bit_cnt   <= '0;
         cur_idx   <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
         byte_idx  <= '0;
         tx_sh     <= '0;
         miso_o    <= 1'b0;
      end else if (!active) begin
         bit_cnt   <= '0;
         cur_idx   <= '0;
         byte_done <= 1'b0;
         tx_sh     <= '0;
         miso_o    <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (rise) begin
            rx_sh   <= {rx_sh[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh, mosi_s};
               byte_idx  <= cur_idx;
               cur_idx   <= cur_idx + 2'd1;
            end
         end
         if (fall) begin
            miso_o <= tx_nxt[7];
            tx_sh  <= {tx_nxt[6:0], 1'b0};
         end else begin
            tx_sh  <= tx_nxt;
         end
      end
   end

   AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso_o) |-> ($past(fall) || !$past(active)));  // R2

   AST_BYTE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(rise));  // R1

endmodule

// File: rtl/spx_page_buf.sv
module spx_page_buf #(
   parameter int PAGE_AW = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_lo,
   input  logic               ld_hi,
   input  logic               ld_ee,
   input  logic [PAGE_AW-1:0] ld_idx,
   input  logic [7:0]         ld_data,
   input  logic               clr_fl,
   input  logic               clr_ee,
   input  logic [PAGE_AW-1:0] rd_idx,
   output logic [15:0]        fl_word,
   output logic [7:0]         ee_byte,
   output logic               ee_loaded
);

   localparam int WORDS = 1 << PAGE_AW;

   generate
      if (PAGE_AW < 1 || PAGE_AW > 10) begin : g_bad_page
         $error("spx_page_buf: PAGE_AW out of range");
      end
   endgenerate

   logic [15:0]      fl_q [WORDS];
   logic [7:0]       ee_q [WORDS];
   logic [WORDS-1:0] lo_ok;
   logic [WORDS-1:0] ee_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) fl_q[w] <= 16'hFFFF;
         lo_ok <= '0;
      end else if (clr_fl) begin
         for (int w = 0; w < WORDS; w++) fl_q[w] <= 16'hFFFF;
         lo_ok <= '0;
      end else if (ld_lo) begin
         fl_q[ld_idx][7:0] <= ld_data;
         lo_ok[ld_idx]     <= 1'b1;
      end else if (ld_hi && lo_ok[ld_idx]) begin
         fl_q[ld_idx][15:8] <= ld_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) ee_q[w] <= 8'h00;
         ee_ok <= '0;
      end else if (clr_ee) begin
         ee_ok <= '0;
      end else if (ld_ee) begin
         ee_q[ld_idx]  <= ld_data;
         ee_ok[ld_idx] <= 1'b1;
      end
   end

   assign fl_word   = fl_q[rd_idx];
   assign ee_byte   = ee_q[rd_idx];
   assign ee_loaded = ee_ok[rd_idx];

   AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo && !clr_fl && !lo_ok[ld_idx]) |=>
         (fl_q[$past(ld_idx)][15:8] == 8'hFF));  // R6

   AST_EE_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ee |=> (ee_ok == '0));  // R8

endmodule

// File: rtl/spx_commit.sv
module spx_commit
   import spx_pkg::*;
#(
   parameter int PAGE_AW     = 6,
   parameter int PAGE_IDX_W  = 7,
   parameter int BUSY_CYCLES = 40
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  commit_kind_e                  kind,
   input  logic [PAGE_AW+PAGE_IDX_W-1:0] addr,
   input  logic [7:0]                    byte_data,
   output logic [PAGE_AW-1:0]            rd_idx,
   input  logic [15:0]                   fl_word,
   input  logic [7:0]                    ee_byte,
   input  logic                          ee_loaded,
   output logic                          clr_fl,
   output logic                          clr_ee,
   output logic                          busy,
   output logic                          mem_we,
   output logic                          mem_eep,
   output logic [PAGE_AW+PAGE_IDX_W-1:0] mem_waddr,
   output logic [15:0]                   mem_wdata
);

   localparam int                 ADDR_W = PAGE_AW + PAGE_IDX_W;
   localparam int                 CNT_W  = $clog2(BUSY_CYCLES + 1);
   localparam logic [PAGE_AW-1:0] LAST   = '1;

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("spx_commit: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   seq_state_e              st;
   commit_kind_e            kind_q;
   logic [PAGE_IDX_W-1:0]   page_q;
   logic [PAGE_AW-1:0]      idx;
   logic [CNT_W-1:0]        cnt;
   logic                    is_flash;

   assign rd_idx   = idx;
   assign busy     = (st != SQ_IDLE);
   assign is_flash = (kind_q == CK_FLASH_PAGE);
   assign clr_fl   = (st == SQ_RUN) && (idx == LAST) && is_flash;
   assign clr_ee   = (st == SQ_RUN) && (idx == LAST) && !is_flash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         kind_q    <= CK_FLASH_PAGE;
         page_q    <= '0;
         idx       <= '0;
         cnt       <= '0;
         mem_we    <= 1'b0;
         mem_eep   <= 1'b0;
         mem_waddr <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  kind_q <= kind;
                  page_q <= addr[ADDR_W-1:PAGE_AW];
                  idx    <= '0;
                  if (kind == CK_EE_BYTE) begin
                     mem_we    <= 1'b1;
                     mem_eep   <= 1'b1;
                     mem_waddr <= addr;
                     mem_wdata <= {8'h00, byte_data};
                     cnt       <= CNT_W'(BUSY_CYCLES);
                     st        <= SQ_HOLD;
                  end else begin
                     st <= SQ_RUN;
                  end
               end
            end
            SQ_RUN: begin
               mem_we    <= is_flash || ee_loaded;
               mem_eep   <= !is_flash;
               mem_waddr <= {page_q, idx};
               mem_wdata <= is_flash ? fl_word : {8'h00, ee_byte};
               idx       <= idx + 1'b1;
               if (idx == LAST) begin
                  cnt <= CNT_W'(BUSY_CYCLES);
                  st  <= SQ_HOLD;
               end
            end
            SQ_HOLD: begin
               if (cnt == '0) st <= SQ_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);  // R13

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);  // R11

endmodule

// File: rtl/spx_target.sv
module spx_target
   import spx_pkg::*;
#(
   parameter int PAGE_AW     = 6,
   parameter int PAGE_IDX_W  = 7,
   parameter int BUSY_CYCLES = 40,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = PAGE_AW + PAGE_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_active,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic              mem_we,
   output logic              mem_eep,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [15:0]       mem_wdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              mem_reep,
   input  logic [15:0]       mem_rdata
);

   generate
      if (ADDR_W > 16) begin : g_bad_addr
         $error("spx_target: page and index bits exceed the 16-bit address field");
      end
   endgenerate

   logic               byte_done;
   logic [7:0]         rx_byte;
   logic [1:0]         byte_idx;
   logic               tx_load;
   logic [7:0]         tx_byte;
   logic [7:0]         b0, b1, b2;
   logic               enabled;
   logic               done_q;
   logic [1:0]         idx_q;
   logic [ADDR_W-1:0]  rd_addr;
   logic               rd_eep;
   logic               busy;
   logic               go;
   logic [15:0]        a16_now;
   logic [15:0]        a16_cmd;
   logic               ld_lo, ld_hi, ld_ee;
   logic               cm_start;
   commit_kind_e       cm_kind;
   logic [PAGE_AW-1:0] buf_rd_idx;
   logic [15:0]        buf_fl_word;
   logic [7:0]         buf_ee_byte;
   logic               buf_ee_loaded;
   logic               clr_fl, clr_ee;

   spx_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (prog_active),
      .sck_i     (sck),
      .mosi_i    (mosi),
      .tx_load   (tx_load),
      .tx_byte   (tx_byte),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .byte_idx  (byte_idx),
      .miso_o    (miso)
   );

   assign a16_now = {b1, rx_byte};
   assign a16_cmd = {b1, b2};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b0      <= '0;
         b1      <= '0;
         b2      <= '0;
         enabled <= 1'b0;
         done_q  <= 1'b0;
         idx_q   <= '0;
         rd_addr <= '0;
         rd_eep  <= 1'b0;
      end else begin
         done_q <= byte_done;
         idx_q  <= byte_idx;
         if (!prog_active) begin
            enabled <= 1'b0;
         end else if (byte_done) begin
            case (byte_idx)
               2'd0: b0 <= rx_byte;
               2'd1: b1 <= rx_byte;
               2'd2: begin
                  b2      <= rx_byte;
                  rd_addr <= a16_now[ADDR_W-1:0];
                  rd_eep  <= (b0 == OP_RD_EE);
               end
               default: begin
                  if (b0 == OP_ENABLE && b1 == SYNC_BYTE) enabled <= 1'b1;
               end
            endcase
         end
      end
   end

   assign go       = prog_active && byte_done && (byte_idx == 2'd3) && enabled && !busy;
   assign ld_lo    = go && (b0 == OP_LD_FL_LO);
   assign ld_hi    = go && (b0 == OP_LD_FL_HI);
   assign ld_ee    = go && (b0 == OP_LD_EE);
   assign cm_start = go && ((b0 == OP_WR_FL_PG) || (b0 == OP_WR_EE_PG) || (b0 == OP_WR_EE_BYTE));

   always_comb begin
      case (b0)
         OP_WR_EE_PG:   cm_kind = CK_EE_PAGE;
         OP_WR_EE_BYTE: cm_kind = CK_EE_BYTE;
         default:       cm_kind = CK_FLASH_PAGE;
      endcase
   end

   assign tx_load = done_q;

   always_comb begin
      tx_byte = 8'h00;
      if (idx_q == 2'd1) begin
         tx_byte = b1;
      end else if (idx_q == 2'd2 && enabled) begin
         case (b0)
            OP_RD_FL_LO: tx_byte = busy ? 8'h00 : mem_rdata[7:0];
            OP_RD_FL_HI: tx_byte = busy ? 8'h00 : mem_rdata[15:8];
            OP_RD_EE:    tx_byte = busy ? 8'h00 : mem_rdata[7:0];
            OP_POLL:     tx_byte = {7'b0, busy};
            default:     tx_byte = 8'h00;
         endcase
      end
   end

   assign mem_raddr = rd_addr;
   assign mem_reep  = rd_eep;

   spx_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_lo     (ld_lo),
      .ld_hi     (ld_hi),
      .ld_ee     (ld_ee),
      .ld_idx    (b2[PAGE_AW-1:0]),
      .ld_data   (rx_byte),
      .clr_fl    (clr_fl),
      .clr_ee    (clr_ee),
      .rd_idx    (buf_rd_idx),
      .fl_word   (buf_fl_word),
      .ee_byte   (buf_ee_byte),
      .ee_loaded (buf_ee_loaded)
   );

   spx_commit #(
      .PAGE_AW     (PAGE_AW),
      .PAGE_IDX_W  (PAGE_IDX_W),
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cm_start),
      .kind      (cm_kind),
      .addr      (a16_cmd[ADDR_W-1:0]),
      .byte_data (rx_byte),
      .rd_idx    (buf_rd_idx),
      .fl_word   (buf_fl_word),
      .ee_byte   (buf_ee_byte),
      .ee_loaded (buf_ee_loaded),
      .clr_fl    (clr_fl),
      .clr_ee    (clr_ee),
      .busy      (busy),
      .mem_we    (mem_we),
      .mem_eep   (mem_eep),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata)
   );

   AST_NO_WRITE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && !busy) |=> !mem_we);  // R4

   AST_QUIET_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_active && $past(!prog_active)) |-> !miso);  // R12

endmodule

// File: tb/spx_target_test.sv
module spx_target_test;

   localparam int ADDR_W = 13;
   localparam int BUSY   = 1500;
   localparam int HALF   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prog_active = 1'b0;
   logic              sck = 1'b0;
   logic              mosi = 1'b0;
   logic              miso;
   logic              mem_we;
   logic              mem_eep;
   logic [ADDR_W-1:0] mem_waddr;
   logic [15:0]       mem_wdata;
   logic [ADDR_W-1:0] mem_raddr;
   logic              mem_reep;
   logic [15:0]       mem_rdata = 16'h0000;

   int n_tests = 0;
   int n_fail  = 0;
   int n_writes = 0;

   logic [15:0] fl_mem [int];
   logic [7:0]  ee_mem [int];
   logic [29:0] exp_q [$];
   logic [29:0] got_item;
   logic [29:0] exp_item;

   always #2 clk = ~clk;

   spx_target #(.BUSY_CYCLES(BUSY)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_active (prog_active),
      .sck         (sck),
      .mosi        (mosi),
      .miso        (miso),
      .mem_we      (mem_we),
      .mem_eep     (mem_eep),
      .mem_waddr   (mem_waddr),
      .mem_wdata   (mem_wdata),
      .mem_raddr   (mem_raddr),
      .mem_reep    (mem_reep),
      .mem_rdata   (mem_rdata)
   );

   // monitor: memory model plus scoreboard of the write stream (R7 R8 R9 R13)
   always @(negedge clk) begin
      if (mem_we) begin
         n_writes++;
         got_item = {mem_eep, mem_waddr, mem_wdata};
         if (mem_eep) ee_mem[int'(mem_waddr)] = mem_wdata[7:0];
         else         fl_mem[int'(mem_waddr)] = mem_wdata;
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4/R11/R13 unexpected write actual %h expected none", got_item);
         end else begin
            exp_item = exp_q.pop_front();
            if (got_item !== exp_item) begin
               n_fail++;
               $display("FAIL R7/R8/R9 write stream actual %h expected %h", got_item, exp_item);
            end
         end
      end
      if (mem_reep) mem_rdata = ee_mem.exists(int'(mem_raddr)) ? {8'h00, ee_mem[int'(mem_raddr)]} : 16'h00FF;
      else          mem_rdata = fl_mem.exists(int'(mem_raddr)) ? fl_mem[int'(mem_raddr)] : 16'hFFFF;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic instr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                        input logic [7:0] d, output logic [31:0] resp);
      logic [7:0] r0, r1, r2, r3;
      xbyte(a, r0);
      xbyte(b, r1);
      xbyte(c, r2);
      xbyte(d, r3);
      resp = {r0, r1, r2, r3};
   endtask

   task automatic wait_idle();
      logic [31:0] r;
      bit idle = 1'b0;
      for (int k = 0; k < 30 && !idle; k++) begin
         instr(8'hF0, 8'h00, 8'h00, 8'h00, r);
         idle = (r[0] == 1'b0);
      end
      check("R11 busy clears", {31'd0, idle}, 32'd1);
   endtask

   task automatic push_write(input logic eep, input logic [ADDR_W-1:0] a, input logic [15:0] d);
      exp_q.push_back({eep, a, d});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int wr_before;
      ee_mem[3] = 8'h5A;
      for (int i = 64; i < 128; i++) ee_mem[i] = 8'(i) ^ 8'h3C;

      repeat (5) @(negedge clk);
      check("R2 miso low in reset", {31'd0, miso}, 32'd0);
      check("R13 no write in reset", {31'd0, mem_we}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      prog_active = 1'b1;
      repeat (4) @(negedge clk);

      // R4: locked before enable
      instr(8'hA0, 8'h00, 8'h03, 8'h00, r);
      check("R4 read before enable", {24'd0, r[7:0]}, 32'h00);
      instr(8'hC0, 8'h00, 8'h10, 8'h99, r);
      repeat (50) @(negedge clk);
      check("R4 no write before enable", n_writes, 0);

      // R1 R3 R5: enable with echo
      instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
      check("R3 R1 enable echo", {24'd0, r[15:8]}, 32'h53);
      instr(8'hA0, 8'h00, 8'h03, 8'h00, r);
      check("R5 R10 R2 eeprom read after enable", {24'd0, r[7:0]}, 32'h5A);
      instr(8'h20, 8'h01, 8'h05, 8'h00, r);
      check("R3 echo of any second byte", {24'd0, r[15:8]}, 32'h01);
      check("R10 flash read of blank word", {24'd0, r[7:0]}, 32'hFF);

      // R9 R11: single write, busy window
      push_write(1'b1, 13'h0010, 16'h0077);
      instr(8'hC0, 8'h00, 8'h10, 8'h77, r);
      instr(8'hF0, 8'h00, 8'h00, 8'h00, r);
      check("R11 poll busy", {24'd0, r[7:0]}, 32'h01);
      instr(8'hC0, 8'h00, 8'h11, 8'h55, r);
      wait_idle();
      instr(8'hA0, 8'h00, 8'h10, 8'h00, r);
      check("R9 single byte written", {24'd0, r[7:0]}, 32'h77);
      instr(8'hA0, 8'h00, 8'h11, 8'h00, r);
      check("R11 write while busy ignored", {24'd0, r[7:0]}, 32'hFF);
      push_write(1'b1, 13'h0003, 16'h00A5);
      instr(8'hC0, 8'h00, 8'h03, 8'hA5, r);
      instr(8'hA0, 8'h00, 8'h03, 8'h00, r);
      check("R11 read while busy returns zero", {24'd0, r[7:0]}, 32'h00);
      wait_idle();
      instr(8'hA0, 8'h00, 8'h03, 8'h00, r);
      check("R9 overwrite is exact", {24'd0, r[7:0]}, 32'hA5);

      // R6 R7: flash page
      instr(8'h40, 8'h00, 8'h05, 8'h34, r);
      instr(8'h48, 8'h00, 8'h05, 8'h12, r);
      instr(8'h48, 8'h00, 8'h09, 8'hEE, r);
      instr(8'h40, 8'h00, 8'h09, 8'hAB, r);
      for (int i = 0; i < 64; i++) begin
         logic [15:0] d;
         d = (i == 5) ? 16'h1234 : (i == 9) ? 16'hFFAB : 16'hFFFF;
         push_write(1'b0, {7'd2, 6'(i)}, d);
      end
      instr(8'h4C, 8'h00, 8'h80, 8'h00, r);
      wait_idle();
      check("R7 full page written", exp_q.size(), 0);
      instr(8'h20, 8'h00, 8'h85, 8'h00, r);
      check("R10 flash low read", {24'd0, r[7:0]}, 32'h34);
      instr(8'h28, 8'h00, 8'h85, 8'h00, r);
      check("R10 flash high read", {24'd0, r[7:0]}, 32'h12);
      instr(8'h28, 8'h00, 8'h89, 8'h00, r);
      check("R6 high before low ignored", {24'd0, r[7:0]}, 32'hFF);
      for (int i = 0; i < 64; i++) push_write(1'b0, {7'd3, 6'(i)}, 16'hFFFF);
      instr(8'h4C, 8'h00, 8'hC0, 8'h00, r);
      wait_idle();
      check("R7 buffer reset to ones", exp_q.size(), 0);

      // R8: eeprom page, only loaded bytes
      instr(8'hC1, 8'h00, 8'h02, 8'h11, r);
      instr(8'hC1, 8'h00, 8'h3C, 8'h22, r);
      push_write(1'b1, 13'h0042, 16'h0011);
      push_write(1'b1, 13'h007C, 16'h0022);
      instr(8'hC2, 8'h00, 8'h40, 8'h00, r);
      wait_idle();
      check("R8 sparse page writes", exp_q.size(), 0);
      instr(8'hA0, 8'h00, 8'h43, 8'h00, r);
      check("R8 unloaded byte kept", {24'd0, r[7:0]}, 32'h7F);
      instr(8'hA0, 8'h00, 8'h7C, 8'h00, r);
      check("R8 loaded byte written", {24'd0, r[7:0]}, 32'h22);
      wr_before = n_writes;
      instr(8'hC2, 8'h00, 8'h40, 8'h00, r);
      wait_idle();
      check("R8 flags cleared after commit", n_writes - wr_before, 0);

      // R12: drop programming-active mid instruction
      begin
         logic [7:0] junk;
         xbyte(8'hAC, junk);
         xbyte(8'h53, junk);
      end
      prog_active = 1'b0;
      repeat (20) @(negedge clk);
      check("R12 miso low while inactive", {31'd0, miso}, 32'd0);
      prog_active = 1'b1;
      repeat (4) @(negedge clk);
      instr(8'hA0, 8'h00, 8'h42, 8'h00, r);
      check("R12 enable withdrawn", {24'd0, r[7:0]}, 32'h00);
      instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
      check("R12 byte counter realigned", {24'd0, r[15:8]}, 32'h53);
      instr(8'hA0, 8'h00, 8'h42, 8'h00, r);
      check("R12 R10 read after re-enable", {24'd0, r[7:0]}, 32'h11);

      repeat (20) @(negedge clk);
      check("R13 no leftover expected writes", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule